// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Cycle Sequencer

This block is a synchronous bus master that carries out one read or one write on a bus where a single group of 16 lines is shared between the low part of a 20-bit physical address and the data word. A requester presents the address, a memory-or-I/O flag, a direction bit and (for writes) a data word. When the sequencer is idle it accepts the request and walks the bus through a fixed series of clock states: T1, T2, T3, zero or more Tw wait states, then T4. It returns the read word and a one-clock completion pulse.

During T1 the address is placed on the shared lines and an address-latch-enable output is raised, so that an external latch can hold the address when that output falls. From T2 onward the shared lines carry data. On a read the block stops driving them and the selected device drives them. On a write the block keeps driving them with the write word. A READY input from the slow side stretches the cycle with wait states. The shared lines are modelled as a separate output value, an output enable and an input value, so that the pads or the bench can combine them.

Top module: `busSeqTop`

## Requirements
- R1: Each accepted request produces exactly one T1 cycle with `ale` high, then a strobe-active span of 2+N clocks (T2, T3 and N wait states), then one T4 clock. In T4 the strobe is high again and `done` is high.
- R2: In T1, `adOe` is 1, `adOut` equals request address bits 15:0 and `addrHi` equals address bits 19:16. An external latch that captures these values at the clock edge where `ale` falls therefore holds the full 20-bit address.
- R3: `memIo` equals the request's memory flag (1 = memory, 0 = I/O) in every clock from T1 through T4.
- R4: On a read, `adOe` is 0 from T2 through T4. `rdN` (active low) is 0 in T2, T3 and every Tw, and is 1 in T4. `rdN` is never 0 while `adOe` is 1.
- R5: `ready` is sampled at the end of T3 and of each Tw. A low sample leads to another Tw, and a high sample leads to T4. While the strobe is active and `ready` is low, the strobe stays active in the next clock.
- R6: On a read, `rdData` in T4 (while `done` is 1) equals the value on `adIn` at the end of the last T3/Tw clock.
- R7: On a write, `wrN` (active low) follows the same timing that R4 gives `rdN`, `rdN` stays 1, and `adOe` is 1 with `adOut` equal to the write word from T2 through T4. `rdN` and `wrN` are never both 0.
- R8: `done` is high for exactly one clock per cycle. `reqReady` is 1 only in the idle state. A request is taken only on a clock edge where `reqValid` and `reqReady` are both 1, and T1 follows in the next clock. A request held while a cycle is in progress starts only after that cycle's `done`.
- R9: After a synchronous reset, `rdN` = 1, `wrN` = 1, `ale` = 0, `adOe` = 0, `done` = 0 and `reqReady` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | High when idle; the request is taken on this edge |
| reqAddr | input | 20 | Physical address |
| reqIsMem | input | 1 | 1 = memory space, 0 = I/O space |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqWdata | input | 16 | Write word |
| rdData | output | 16 | Read word, valid while done is high after a read |
| done | output | 1 | One-clock completion pulse in T4 |
| ale | output | 1 | Address latch enable, high in T1 |
| rdN | output | 1 | Read strobe, active low |
| wrN | output | 1 | Write strobe, active low |
| memIo | output | 1 | Memory/I-O select for the cycle |
| addrHi | output | 4 | Address bits 19:16 |
| adOut | output | 16 | Value driven onto the shared lines |
| adOe | output | 1 | Drive enable for the shared lines |
| adIn | input | 16 | Value seen on the shared lines |
| ready | input | 1 | Device ready; low inserts wait states |

## Verification
A wrong control state shows up at the ports within one clock. A sequencer that skips or repeats a state changes the number of strobe-low clocks or the clock in which `done` rises in that same cycle. A wrong turnaround shows as `adOe` and `rdN` active together in the first T2 clock. A datapath fault, such as a stale address, the wrong capture edge or the wrong drive word, shows only at T4: the latched address, the written memory word or `rdData` differs from the value the modelled memory holds. The bench therefore compares every completed cycle against that model before the next cycle begins.

// File: rtl/busSeqPkg.sv
package busSeqPkg;

  typedef enum logic [2:0] {
    S_IDLE = 3'd0,
    S_T1   = 3'd1,
    S_T2   = 3'd2,
    S_T3   = 3'd3,
    S_TW   = 3'd4,
    S_T4   = 3'd5
  } busState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic loadReq;    // take the request into the holding registers
    logic driveAddr;  // put address low part on shared lines
    logic driveData;  // put write word on shared lines
    logic captureRd;  // register the shared lines into read data
  } dpStrobe_t;

endpackage

// File: rtl/busSeqCtrl.sv
module busSeqCtrl
  import busSeqPkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      reqValid,
  input  logic      reqWrite,
  input  logic      ready,
  output dpStrobe_t strobes,
  output logic      reqReady,
  output logic      ale,
  output logic      rdN,
  output logic      wrN,
  output logic      done
);

  busState_e state;
  busState_e nextState;
  logic      isWrite;
  logic      strobeSpan;
  logic      sampleSlot;

  always_comb begin
    nextState = state;
    unique case (state)
      S_IDLE:  if (reqValid) nextState = S_T1;
      S_T1:    nextState = S_T2;
      S_T2:    nextState = S_T3;
      S_T3,
      S_TW:    nextState = ready ? S_T4 : S_TW;
      S_T4:    nextState = S_IDLE;
      default: nextState = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= S_IDLE;
      isWrite <= 1'b0;
    end else begin
      state <= nextState;
      if (state == S_IDLE && reqValid) isWrite <= reqWrite;
    end
  end

  assign strobeSpan = (state == S_T2) || (state == S_T3) || (state == S_TW);
  assign sampleSlot = (state == S_T3) || (state == S_TW);

  assign reqReady = (state == S_IDLE);
  assign ale      = (state == S_T1);
  assign rdN      = !(strobeSpan && !isWrite);
  assign wrN      = !(strobeSpan && isWrite);
  assign done     = (state == S_T4);

  always_comb begin
    strobes.loadReq   = (state == S_IDLE) && reqValid;
    strobes.driveAddr = (state == S_T1);
    strobes.driveData = isWrite && (strobeSpan || state == S_T4);
    strobes.captureRd = !isWrite && sampleSlot && ready;
  end

endmodule

// File: rtl/busSeqDatapath.sv
module busSeqDatapath
  import busSeqPkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16,
  localparam int HI_W  = ADDR_W - DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  dpStrobe_t         strobes,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqIsMem,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [DATA_W-1:0] adIn,
  output logic [DATA_W-1:0] adOut,
  output logic              adOe,
  output logic [HI_W-1:0]   addrHi,
  output logic              memIo,
  output logic [DATA_W-1:0] rdData
);

  logic [ADDR_W-1:0] addrReg;
  logic [DATA_W-1:0] wdataReg;
  logic              memIoReg;
  logic [DATA_W-1:0] rdDataReg;

  always_ff @(posedge clk) begin
    if (rst) begin
      addrReg   <= '0;
      wdataReg  <= '0;
      memIoReg  <= 1'b0;
      rdDataReg <= '0;
    end else begin
      if (strobes.loadReq) begin
        addrReg  <= reqAddr;
        wdataReg <= reqWdata;
        memIoReg <= reqIsMem;
      end
      if (strobes.captureRd) rdDataReg <= adIn;
    end
  end

  always_comb begin
    if (strobes.driveAddr)      adOut = addrReg[DATA_W-1:0];
    else if (strobes.driveData) adOut = wdataReg;
    else                        adOut = '0;
  end

  assign adOe   = strobes.driveAddr || strobes.driveData;
  assign addrHi = addrReg[ADDR_W-1:DATA_W];
  assign memIo  = memIoReg;
  assign rdData = rdDataReg;

endmodule

// File: rtl/busSeqTop.sv
module busSeqTop
  import busSeqPkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16,
  localparam int HI_W  = ADDR_W - DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqIsMem,
  input  logic              reqWrite,
  input  logic [DATA_W-1:0] reqWdata,
  output logic [DATA_W-1:0] rdData,
  output logic              done,
  output logic              ale,
  output logic              rdN,
  output logic              wrN,
  output logic              memIo,
  output logic [HI_W-1:0]   addrHi,
  output logic [DATA_W-1:0] adOut,
  output logic              adOe,
  input  logic [DATA_W-1:0] adIn,
  input  logic              ready
);

  dpStrobe_t strobes;

  busSeqCtrl ctrl_i (
    .clk      (clk),
    .rst      (rst),
    .reqValid (reqValid),
    .reqWrite (reqWrite),
    .ready    (ready),
    .strobes  (strobes),
    .reqReady (reqReady),
    .ale      (ale),
    .rdN      (rdN),
    .wrN      (wrN),
    .done     (done)
  );

  busSeqDatapath #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) dp_i (
    .clk      (clk),
    .rst      (rst),
    .strobes  (strobes),
    .reqAddr  (reqAddr),
    .reqIsMem (reqIsMem),
    .reqWdata (reqWdata),
    .adIn     (adIn),
    .adOut    (adOut),
    .adOe     (adOe),
    .addrHi   (addrHi),
    .memIo    (memIo),
    .rdData   (rdData)
  );

endmodule

// File: rtl/busSeqChecker.sv
module busSeqChecker (
  input logic clk,
  input logic rst,
  input logic reqValid,
  input logic reqReady,
  input logic ready,
  input logic ale,
  input logic rdN,
  input logic wrN,
  input logic adOe,
  input logic memIo,
  input logic done
);

  // R4
  no_contention_chk: assert property (@(posedge clk) disable iff (rst)
    !(adOe && !rdN));

  // R7
  strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(!rdN && !wrN));

  // R1
  ale_to_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    ale |=> (!ale && (!rdN || !wrN)));

  // R5
  wait_hold_chk: assert property (@(posedge clk) disable iff (rst)
    ((!rdN || !wrN) && !ready) |=> (!rdN || !wrN));

  // R3
  memio_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (!rdN || !wrN || done) |-> $stable(memIo));

  // R8
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R8
  accept_chk: assert property (@(posedge clk) disable iff (rst)
    (reqValid && reqReady) |=> ale);

  // R8
  busy_chk: assert property (@(posedge clk) disable iff (rst)
    (ale || !rdN || !wrN || done) |-> !reqReady);

endmodule

bind busSeqTop busSeqChecker chk_i (
  .clk      (clk),
  .rst      (rst),
  .reqValid (reqValid),
  .reqReady (reqReady),
  .ready    (ready),
  .ale      (ale),
  .rdN      (rdN),
  .wrN      (wrN),
  .adOe     (adOe),
  .memIo    (memIo),
  .done     (done)
);

// File: tb/busSeqTop_tb_top.sv
module busSeqTop_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [19:0] reqAddr = '0;
  logic        reqIsMem = 1'b0;
  logic        reqWrite = 1'b0;
  logic [15:0] reqWdata = '0;
  logic [15:0] rdData;
  logic        done;
  logic        ale;
  logic        rdN;
  logic        wrN;
  logic        memIo;
  logic [3:0]  addrHi;
  logic [15:0] adOut;
  logic        adOe;
  logic [15:0] adIn;
  logic        ready = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  busSeqTop dut_i (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqReady(reqReady),
    .reqAddr(reqAddr), .reqIsMem(reqIsMem), .reqWrite(reqWrite),
    .reqWdata(reqWdata), .rdData(rdData), .done(done), .ale(ale),
    .rdN(rdN), .wrN(wrN), .memIo(memIo), .addrHi(addrHi), .adOut(adOut),
    .adOe(adOe), .adIn(adIn), .ready(ready)
  );

  typedef struct {
    bit          wr;
    bit          isMem;
    logic [19:0] addr;
    logic [15:0] data;
    int          waitN;
  } item_t;

  item_t       sbQ[$];
  item_t       cur;
  int          total = 0;
  int          failed = 0;
  bit          finished = 0;
  logic [15:0] memArr [2][256];
  logic [19:0] latchAddr = '0;

  task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (!ok) begin
      failed++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // memory model: address latch closes where ale falls
  always @(posedge clk) begin
    if (ale) latchAddr <= {addrHi, adOut};
    if (!wrN) memArr[memIo][latchAddr[7:0]] <= adOut;
  end

  assign adIn = !rdN ? memArr[memIo][latchAddr[7:0]] : (adOe ? adOut : 16'hFFFF);

  // monitor / scoreboard
  int lowCnt = 0, lastLow = 0;
  bit inCycle = 0, prevDone = 0, holdFault = 0;
  bit badContend = 0, badMemIo = 0, badWr = 0, badRdy = 0, badRdBus = 0;

  always @(negedge clk) begin
    if (!rst && !finished) begin
      if (ale) begin
        if (inCycle) holdFault = 1;
        inCycle = 1;
        if (sbQ.size() > 0) cur = sbQ[0];
        badContend = 0; badMemIo = 0; badWr = 0; badRdy = 0; badRdBus = 0;
      end
      if (inCycle) begin
        if (memIo !== cur.isMem) badMemIo = 1;
        if (reqReady) badRdy = 1;
        if (!cur.wr && !ale && adOe) badRdBus = 1;
        if (cur.wr && !ale && (!adOe || adOut !== cur.data || !rdN)) badWr = 1;
      end
      if (adOe && !rdN) badContend = 1;
      if (!rdN || !wrN) lowCnt++;
      else if (lowCnt != 0) begin
        lastLow = lowCnt;
        lowCnt = 0;
      end
      ready = (lowCnt >= 2 + cur.waitN);
      if (done && prevDone) chk(0, "R8", "done wider than one clock", 2, 1);
      if (done) begin
        chk(lastLow == 2 + cur.waitN, "R1", "strobe-low clocks", lastLow, 2 + cur.waitN);
        chk(latchAddr == cur.addr, "R2", "latched address", latchAddr, cur.addr);
        chk(!badMemIo, "R3", "memIo during cycle", badMemIo, 0);
        chk(!badContend, "R4", "shared-line contention", badContend, 0);
        chk(!holdFault && !badRdy, "R8", "hold-off while busy", {holdFault, badRdy}, 0);
        if (cur.wr) begin
          chk(!badWr, "R7", "write drive/strobe", badWr, 0);
          chk(memArr[cur.isMem][cur.addr[7:0]] == cur.data, "R7", "word stored",
              memArr[cur.isMem][cur.addr[7:0]], cur.data);
        end else begin
          chk(!badRdBus, "R4", "bus released on read", badRdBus, 0);
          chk(rdData == memArr[cur.isMem][cur.addr[7:0]], "R6", "read data",
              rdData, memArr[cur.isMem][cur.addr[7:0]]);
        end
        if (sbQ.size() > 0) void'(sbQ.pop_front());
        inCycle = 0;
        holdFault = 0;
      end
      prevDone = done;
    end
  end

  // driver: push the expected item once the request is taken
  task automatic issue(bit wr, bit isMem, logic [19:0] a, logic [15:0] d, int w);
    item_t it;
    it.wr = wr; it.isMem = isMem; it.addr = a; it.data = d; it.waitN = w;
    @(negedge clk);
    reqValid = 1; reqWrite = wr; reqIsMem = isMem; reqAddr = a; reqWdata = d;
    while (!reqReady) @(negedge clk);
    @(posedge clk);
    #1;
    sbQ.push_back(it);
    reqValid = 0;
  endtask

  int cycles = 0;
  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !finished) begin
      finished = 1;
      total++;
      failed++;
      $display("FAIL watchdog: actual %0d expected <20000 cycles", cycles);
      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
    end
  end

  initial begin
    cur = '{wr: 0, isMem: 0, addr: '0, data: '0, waitN: 0};
    for (int i = 0; i < 256; i++) begin
      memArr[0][i] = 16'h1000 + 16'(i * 3);
      memArr[1][i] = 16'hC000 ^ 16'(i * 257);
    end
    repeat (3) @(posedge clk);
    #1 rst = 0;
    @(negedge clk);
    // R9 reset state at the ports
    chk(rdN === 1'b1 && wrN === 1'b1, "R9", "strobes after reset", {rdN, wrN}, 2'b11);
    chk(ale === 1'b0 && adOe === 1'b0, "R9", "ale/adOe after reset", {ale, adOe}, 0);
    chk(done === 1'b0 && reqReady === 1'b1, "R9", "done/reqReady after reset", {done, reqReady}, 1);

    issue(1, 1, 20'h3_0012, 16'hA1B2, 0);   // R7 write, no wait
    issue(0, 1, 20'h3_0012, 16'h0000, 0);   // R6 read back, no wait
    issue(0, 1, 20'h1_0044, 16'h0000, 1);   // R5 one wait
    issue(1, 0, 20'h0_00FE, 16'h5AC3, 3);   // R3 I/O write, several waits
    issue(0, 0, 20'h0_00FE, 16'h0000, 2);   // I/O read back
    issue(0, 1, 20'h0_00FE, 16'h0000, 0);   // memory space unaffected
    issue(1, 1, 20'hF_FF80, 16'h0F0F, 1);
    issue(0, 1, 20'hF_FF80, 16'h0000, 5);   // R5 long stretch
    repeat (40) @(negedge clk);
    chk(sbQ.size() == 0, "R8", "all requests completed", sbQ.size(), 0);
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
    end
  end

endmodule